// File: doc/BRIEF.md
# Interrupt and Memory-Field Controller

This block keeps the interrupt-enable state and the extended-memory field registers of a 12-bit word processor, and it decodes the I/O-transfer instructions that act on them. The processor core passes it each fetch, each executed instruction word and each committed jump or subroutine call. It answers with a combinational skip request, a value to OR into the accumulator, accumulator and device-flag clear strobes, and a take-interrupt flag. The core samples that flag at the next fetch.

Interrupt entry is held off by two one-instruction delays. One delay follows turning interrupts on. The other follows any staged change of instruction field or user mode. A new instruction field is written into a buffer and copied into the live field register only when a jump or call executes. On entry the live fields and the user flag are packed into a 7-bit save register and then cleared. The core writes its PC to word 0 of field 0 and fetches from word 1.

Top module: `intr_field_ctl`

## Requirements
- R1: `take_o` is high only when interrupts are on, neither the on-delay nor the field-change delay is pending, and at least one `dev_req_i` line or the user-trap flag is set.
- R2: A cycle with `fetch_i` and `take_o` both high turns interrupts off. It loads the save field as {UF, IF[2:0], DF[2:0]} (bit 6 down to bit 0) and clears IF, DF, UF, the instruction buffer and the user buffer.
- R3: The interrupt-on code (IR = octal 6001) sets interrupts on and arms the on-delay. Every fetch clears the on-delay, so exactly one further instruction runs before `take_o` can rise.
- R4: A field-change code loads only the instruction buffer and arms the field-change delay. `if_o` keeps its value until a cycle with `jump_i`. That cycle copies the buffer into IF and the user buffer into UF, and releases the delay.
- R5: Field codes have IR[11:6] = 110 010 with the field value in IR[5:3]. Pulse IR[2:0] = 1 loads DF. Pulse 2 does the R4 field change. Pulse 3 does both.
- R6: Pulse 4 with IR[5:3] = 1 ORs DF<<3 into `ac_or_o`. IR[5:3] = 2 ORs IF<<3. IR[5:3] = 3 ORs the 7-bit save field, zero-extended.
- R7: Pulse 4 with IR[5:3] = 4 loads the user buffer, the instruction buffer and DF from save-field bits 6, 5:3 and 2:0. IR[5:3] = 6 clears the user buffer and IR[5:3] = 7 sets it. All three arm the field-change delay.
- R8: Device-0 codes (IR[11:3] = 110 000 000): pulse 0 requests a skip if interrupts are on and then turns them off. Pulse 2 turns interrupts off. Pulse 3 requests a skip if any request line or the user trap is set.
- R9: Device-0 pulse 7 raises `ac_clr_o` and `dev_clr_o` for that cycle. It turns interrupts off and clears the on-delay and the user trap.
- R10: While UF is set, every I/O-transfer code (IR[11:9] = 110) has no effect and sets the user trap. Pulse 4 with IR[5:3] = 5 requests a skip when the trap is set, and with IR[5:3] = 0 it clears the trap.
- R11: After reset, interrupts are off, all delays, UF and the user buffer are clear, and DF and the instruction buffer equal IF (field 0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_i | input | 1 | An instruction fetch (or interrupt entry in its place) completes this cycle |
| exec_i | input | 1 | `ir_i` is executed this cycle |
| jump_i | input | 1 | A jump or subroutine call is executed this cycle |
| ir_i | input | 12 | Instruction word |
| dev_req_i | input | NREQ | Device interrupt request lines |
| take_o | output | 1 | Interrupt must be taken at this fetch |
| if_o | output | 3 | Current instruction field |
| df_o | output | 3 | Current data field |
| uf_o | output | 1 | User mode flag |
| ion_o | output | 1 | Interrupts on |
| ac_or_o | output | 12 | Value to OR into the accumulator |
| ac_clr_o | output | 1 | Clear the accumulator |
| skip_o | output | 1 | Skip the next instruction |
| dev_clr_o | output | 1 | Clear all device flags and restore default enables |

## Verification
The assertions assume that `fetch_i` and `exec_i` are never high in the same cycle. They also assume that `jump_i` only comes with a word whose IR[11:9] is not 110, so a field code and a commit never coincide. The bench drives one strobe per clock from tasks, puts each jump on an octal 5000 word, and holds the strobes low in all other cycles. Request lines change only between instructions, which matches how a core presents them.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int WORD_W = 12;
  localparam int FLD_W  = 3;
  localparam int SAVE_W = 1 + 2 * FLD_W;

  typedef enum logic [4:0] {
    OP_NONE, OP_SKON, OP_ION, OP_IOF, OP_SRQ, OP_CAF,
    OP_CDF, OP_CIF, OP_CDFCIF, OP_CINT, OP_RDF, OP_RIF,
    OP_RIB, OP_RMF, OP_SINT, OP_CUF, OP_SUF, OP_UTRAP
  } iot_op_e;

  // Classify an instruction word; user mode turns any transfer into a trap.
  function automatic iot_op_e iot_classify(input logic [WORD_W-1:0] ir,
                                           input logic user);
    iot_op_e op;
    op = OP_NONE;
    if (ir[11:9] == 3'b110) begin
      if (user) op = OP_UTRAP;
      else if (ir[8:3] == 6'o00) begin
        case (ir[2:0])
          3'd0: op = OP_SKON;
          3'd1: op = OP_ION;
          3'd2: op = OP_IOF;
          3'd3: op = OP_SRQ;
          3'd7: op = OP_CAF;
          default: op = OP_NONE;
        endcase
      end else if (ir[8:6] == 3'b010) begin
        case (ir[2:0])
          3'd1: op = OP_CDF;
          3'd2: op = OP_CIF;
          3'd3: op = OP_CDFCIF;
          3'd4: begin
            case (ir[5:3])
              3'd0: op = OP_CINT;
              3'd1: op = OP_RDF;
              3'd2: op = OP_RIF;
              3'd3: op = OP_RIB;
              3'd4: op = OP_RMF;
              3'd5: op = OP_SINT;
              3'd6: op = OP_CUF;
              default: op = OP_SUF;
            endcase
          end
          default: op = OP_NONE;
        endcase
      end
    end
    return op;
  endfunction

  function automatic logic [SAVE_W-1:0] pack_save(input logic uf,
                                                  input logic [FLD_W-1:0] ifld,
                                                  input logic [FLD_W-1:0] dfld);
    return {uf, ifld, dfld};
  endfunction

  // Place a field value at bit FLD_W of an accumulator-wide word.
  function automatic logic [WORD_W-1:0] field_to_ac(input logic [FLD_W-1:0] f);
    return {{(WORD_W-2*FLD_W){1'b0}}, f, {FLD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/ifc_decode.sv
module ifc_decode
  import ifc_pkg::*;
(
  input  logic              exec_i,
  input  logic              user_i,
  input  logic [WORD_W-1:0] ir_i,
  output iot_op_e           op_o
);
  assign op_o = exec_i ? iot_classify(ir_i, user_i) : OP_NONE;
endmodule

// File: rtl/ifc_intr_state.sv
module ifc_intr_state
  import ifc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fetch_i,
  input  logic    jump_i,
  input  iot_op_e op_i,
  input  logic    req_any_i,
  output logic    take_o,
  output logic    ion_o,
  output logic    utrap_o
);
  logic ion_q, ion_dly_q, cif_dly_q, utrap_q;
  logic enter;

  assign take_o  = ion_q && !ion_dly_q && !cif_dly_q && (req_any_i || utrap_q);
  assign enter   = fetch_i && take_o;
  assign ion_o   = ion_q;
  assign utrap_o = utrap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ion_q     <= 1'b0;
      ion_dly_q <= 1'b0;
      cif_dly_q <= 1'b0;
      utrap_q   <= 1'b0;
    end else begin
      if (fetch_i) begin
        ion_dly_q <= 1'b0;
        if (enter) ion_q <= 1'b0;
      end
      case (op_i)
        OP_ION: begin ion_q <= 1'b1; ion_dly_q <= 1'b1; end
        OP_SKON, OP_IOF: ion_q <= 1'b0;
        OP_CAF: begin ion_q <= 1'b0; ion_dly_q <= 1'b0; utrap_q <= 1'b0; end
        OP_CIF, OP_CDFCIF, OP_RMF, OP_CUF, OP_SUF: cif_dly_q <= 1'b1;
        OP_CINT:  utrap_q <= 1'b0;
        OP_UTRAP: utrap_q <= 1'b1;
        default: ;
      endcase
      if (jump_i) cif_dly_q <= 1'b0;
    end
  end

  a_r2_entry_ion_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && take_o) |=> !ion_q);
  a_r3_ion_arms_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ION && !fetch_i) |=> (ion_q && ion_dly_q && !take_o));
  a_r3_fetch_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && op_i != OP_ION) |=> !ion_dly_q);
  a_r4_jump_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_i && op_i == OP_NONE) |=> !cif_dly_q);
  a_r10_trap_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_UTRAP) |=> utrap_q);
endmodule

// File: rtl/ifc_field_regs.sv
module ifc_field_regs
  import ifc_pkg::*;
#(
  parameter logic [ifc_pkg::FLD_W-1:0] RST_FIELD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_i,
  input  logic              jump_i,
  input  iot_op_e           op_i,
  input  logic [FLD_W-1:0]  fld_i,
  output logic [FLD_W-1:0]  if_o,
  output logic [FLD_W-1:0]  df_o,
  output logic              uf_o,
  output logic [SAVE_W-1:0] sf_o
);
  logic [FLD_W-1:0]  if_q, ib_q, df_q;
  logic              uf_q, ub_q;
  logic [SAVE_W-1:0] sf_q;

  assign if_o = if_q;
  assign df_o = df_q;
  assign uf_o = uf_q;
  assign sf_o = sf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_q <= RST_FIELD;
      ib_q <= RST_FIELD;
      df_q <= RST_FIELD;
      uf_q <= 1'b0;
      ub_q <= 1'b0;
      sf_q <= '0;
    end else if (enter_i) begin
      sf_q <= pack_save(uf_q, if_q, df_q);
      if_q <= '0;
      ib_q <= '0;
      df_q <= '0;
      uf_q <= 1'b0;
      ub_q <= 1'b0;
    end else begin
      if (jump_i) begin
        if_q <= ib_q;
        uf_q <= ub_q;
      end
      case (op_i)
        OP_CDF:    df_q <= fld_i;
        OP_CIF:    ib_q <= fld_i;
        OP_CDFCIF: begin df_q <= fld_i; ib_q <= fld_i; end
        OP_RMF: begin
          ub_q <= sf_q[2*FLD_W];
          ib_q <= sf_q[2*FLD_W-1:FLD_W];
          df_q <= sf_q[FLD_W-1:0];
        end
        OP_CUF: ub_q <= 1'b0;
        OP_SUF: ub_q <= 1'b1;
        default: ;
      endcase
    end
  end

  a_r2_fields_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> (if_q == '0 && df_q == '0 && ib_q == '0 && !uf_q && !ub_q));
  a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_i && !enter_i) |=> (if_q == $past(ib_q) && uf_q == $past(ub_q)));
  a_r4_cif_holds_if: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CIF && !jump_i && !enter_i) |=> ($stable(if_q) && ib_q == $past(fld_i)));
  a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RMF && !enter_i) |=> (df_q == $past(sf_q[FLD_W-1:0])));
endmodule

// File: rtl/intr_field_ctl.sv
module intr_field_ctl
  import ifc_pkg::*;
#(
  parameter int NREQ = 4,
  parameter logic [ifc_pkg::FLD_W-1:0] RST_FIELD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_i,
  input  logic              exec_i,
  input  logic              jump_i,
  input  logic [11:0]       ir_i,
  input  logic [NREQ-1:0]   dev_req_i,
  output logic              take_o,
  output logic [2:0]        if_o,
  output logic [2:0]        df_o,
  output logic              uf_o,
  output logic              ion_o,
  output logic [11:0]       ac_or_o,
  output logic              ac_clr_o,
  output logic              skip_o,
  output logic              dev_clr_o
);
  iot_op_e           op;
  logic              utrap, enter, req_any;
  logic [SAVE_W-1:0] sf;

  assign req_any = |dev_req_i;
  assign enter   = fetch_i && take_o;

  ifc_decode u_dec (
    .exec_i (exec_i),
    .user_i (uf_o),
    .ir_i   (ir_i),
    .op_o   (op)
  );

  ifc_intr_state u_intr (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_i   (fetch_i),
    .jump_i    (jump_i),
    .op_i      (op),
    .req_any_i (req_any),
    .take_o    (take_o),
    .ion_o     (ion_o),
    .utrap_o   (utrap)
  );

  ifc_field_regs #(.RST_FIELD(RST_FIELD)) u_fld (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter_i (enter),
    .jump_i  (jump_i),
    .op_i    (op),
    .fld_i   (ir_i[5:3]),
    .if_o    (if_o),
    .df_o    (df_o),
    .uf_o    (uf_o),
    .sf_o    (sf)
  );

  always_comb begin
    ac_or_o   = '0;
    skip_o    = 1'b0;
    ac_clr_o  = 1'b0;
    dev_clr_o = 1'b0;
    case (op)
      OP_RDF:  ac_or_o = field_to_ac(df_o);
      OP_RIF:  ac_or_o = field_to_ac(if_o);
      OP_RIB:  ac_or_o = {{(WORD_W-SAVE_W){1'b0}}, sf};
      OP_SKON: skip_o  = ion_o;
      OP_SRQ:  skip_o  = req_any || utrap;
      OP_SINT: skip_o  = utrap;
      OP_CAF:  begin ac_clr_o = 1'b1; dev_clr_o = 1'b1; end
      default: ;
    endcase
  end

  a_r10_user_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && uf_o && ir_i[11:9] == 3'b110) |->
      (ac_or_o == '0 && !skip_o && !ac_clr_o && !dev_clr_o));
  a_r1_take_needs_ion: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ion_o);
  a_r9_clear_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ac_clr_o |=> !ion_o);
endmodule

// File: tb/intr_field_ctl_bench.sv
module intr_field_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n, fetch_i, exec_i, jump_i;
  logic [11:0] ir_i;
  logic [3:0]  dev_req_i;
  logic        take_o, uf_o, ion_o, ac_clr_o, skip_o, dev_clr_o;
  logic [2:0]  if_o, df_o;
  logic [11:0] ac_or_o;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  intr_field_ctl u_intr_field_ctl (
    .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .exec_i(exec_i),
    .jump_i(jump_i), .ir_i(ir_i), .dev_req_i(dev_req_i), .take_o(take_o),
    .if_o(if_o), .df_o(df_o), .uf_o(uf_o), .ion_o(ion_o), .ac_or_o(ac_or_o),
    .ac_clr_o(ac_clr_o), .skip_o(skip_o), .dev_clr_o(dev_clr_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fetch_i = 1'b0; exec_i = 1'b0; jump_i = 1'b0;
    ir_i = 12'o7000; dev_req_i = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Execute one word; comb outputs are sampled mid-cycle before the edge.
  task automatic run(input logic [11:0] ir, input logic jmp,
                     output logic [11:0] aco, output logic skp, output logic clr);
    @(negedge clk);
    exec_i = 1'b1; ir_i = ir; jump_i = jmp;
    #5;
    aco = ac_or_o; skp = skip_o; clr = ac_clr_o && dev_clr_o;
    @(negedge clk);
    exec_i = 1'b0; jump_i = 1'b0; ir_i = 12'o7000;
  endtask

  task automatic fetch(output logic tk);
    @(negedge clk);
    fetch_i = 1'b1;
    #5;
    tk = take_o;
    @(negedge clk);
    fetch_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    dev_req_i = 4'b0001;
    #5;
    check("R11 if", if_o, 0);
    check("R11 df", df_o, 0);
    check("R11 uf", uf_o, 0);
    check("R11 ion", ion_o, 0);
    check("R1 no take while off", take_o, 0);
  endtask

  task automatic t_fields();
    logic [11:0] a; logic s, c;
    do_reset();
    run(12'o6231, 1'b0, a, s, c);
    check("R5 cdf loads df", df_o, 3);
    run(12'o6214, 1'b0, a, s, c);
    check("R6 rdf", a, 12'o0030);
    run(12'o6252, 1'b0, a, s, c);
    check("R4 cif leaves if", if_o, 0);
    run(12'o6224, 1'b0, a, s, c);
    check("R6 rif before commit", a, 0);
    run(12'o5000, 1'b1, a, s, c);
    check("R4 commit on jump", if_o, 5);
    run(12'o6224, 1'b0, a, s, c);
    check("R6 rif after commit", a, 12'o0050);
    run(12'o6223, 1'b0, a, s, c);
    run(12'o5000, 1'b1, a, s, c);
    check("R5 both df", df_o, 2);
    check("R5 both if", if_o, 2);
  endtask

  task automatic t_ion_defer();
    logic [11:0] a; logic s, c, tk;
    do_reset();
    run(12'o6223, 1'b0, a, s, c);
    run(12'o5000, 1'b1, a, s, c);
    dev_req_i = 4'b0100;
    run(12'o6001, 1'b0, a, s, c);
    fetch(tk);
    check("R3 first fetch after on held", tk, 0);
    run(12'o7000, 1'b0, a, s, c);
    fetch(tk);
    check("R1 take after one instr", tk, 1);
    check("R2 ion off", ion_o, 0);
    check("R2 if cleared", if_o, 0);
    check("R2 df cleared", df_o, 0);
    run(12'o6234, 1'b0, a, s, c);
    check("R6 rib save field", a, 12'o0022);
  endtask

  task automatic t_cif_defer();
    logic [11:0] a; logic s, c, tk;
    do_reset();
    run(12'o6001, 1'b0, a, s, c);
    fetch(tk);
    check("R3 no req no take", tk, 0);
    run(12'o6202, 1'b0, a, s, c);
    dev_req_i = 4'b1000;
    fetch(tk);
    check("R4 field delay holds", tk, 0);
    run(12'o5000, 1'b1, a, s, c);
    fetch(tk);
    check("R4 take after jump", tk, 1);
  endtask

  task automatic t_dev0();
    logic [11:0] a; logic s, c, tk;
    do_reset();
    run(12'o6003, 1'b0, a, s, c);
    check("R8 srq idle", s, 0);
    dev_req_i = 4'b0010;
    run(12'o6003, 1'b0, a, s, c);
    check("R8 srq pending", s, 1);
    dev_req_i = '0;
    run(12'o6001, 1'b0, a, s, c);
    fetch(tk);
    run(12'o6000, 1'b0, a, s, c);
    check("R8 skon on", s, 1);
    run(12'o6000, 1'b0, a, s, c);
    check("R8 skon off", s, 0);
    run(12'o6001, 1'b0, a, s, c);
    run(12'o6002, 1'b0, a, s, c);
    check("R8 iof", ion_o, 0);
    run(12'o6001, 1'b0, a, s, c);
    run(12'o6007, 1'b0, a, s, c);
    check("R9 clear strobes", c, 1);
    check("R9 ion off", ion_o, 0);
  endtask

  task automatic t_user();
    logic [11:0] a; logic s, c, tk;
    do_reset();
    run(12'o6251, 1'b0, a, s, c);
    run(12'o6001, 1'b0, a, s, c);
    fetch(tk);
    run(12'o6274, 1'b0, a, s, c);
    run(12'o5000, 1'b1, a, s, c);
    check("R7 suf then jump", uf_o, 1);
    fetch(tk);
    check("R1 no trap no take", tk, 0);
    run(12'o6214, 1'b0, a, s, c);
    check("R10 suppressed or", a, 0);
    check("R10 still df 5", df_o, 5);
    fetch(tk);
    check("R1 trap takes", tk, 1);
    check("R2 uf cleared", uf_o, 0);
    run(12'o6234, 1'b0, a, s, c);
    check("R6 rib with uf", a, 12'o0105);
    run(12'o6254, 1'b0, a, s, c);
    check("R10 sint set", s, 1);
    run(12'o6204, 1'b0, a, s, c);
    run(12'o6254, 1'b0, a, s, c);
    check("R10 sint cleared", s, 0);
    run(12'o6244, 1'b0, a, s, c);
    check("R7 restore df", df_o, 5);
    run(12'o5000, 1'b1, a, s, c);
    check("R7 restore ub", uf_o, 1);
  endtask

  task automatic t_cuf();
    logic [11:0] a; logic s, c;
    do_reset();
    run(12'o6274, 1'b0, a, s, c);
    run(12'o6264, 1'b0, a, s, c);
    run(12'o5000, 1'b1, a, s, c);
    check("R7 cuf wins", uf_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fields();
    t_ion_defer();
    t_cif_defer();
    t_dev0();
    t_user();
    t_cuf();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule